// File: doc/BRIEF.md
# Banked clock divider and selector

This block takes a fast source clock and derives two clocks from it: one at half its rate and one at a quarter of its rate. Both have a 50% duty cycle whatever the duty cycle of the source. The block drives twelve outputs arranged as four banks of three. A two-bit select picks, for each of the first three banks, whether that bank carries the half-rate clock or the quarter-rate clock. The fourth bank always carries the half-rate clock.

Three controls sit beside the select. An active-low enable forces every output low when it is high, and the dividers keep counting underneath. The falling edge of a clear input resets the quarter-rate divider alone. A bypass mode sends the undivided source clock to every output, and the enable still gates it. A synchronous reset puts both dividers at zero.

The divider after a clear is built so that the quarter-rate clock always rises on a rising edge of the half-rate clock. This keeps the banks phase-related for a feedback loop that sits outside the block.

Top module: `clk_bank_divider`

## Requirements
- R1: While `rst` is high, both dividers sit at 0 at each rising edge, so every output is low with `oe_n` low and `bypass` low.
- R2: Out of reset, the half-rate clock toggles on every rising edge of `clk_src`. It is high for exactly half of any even run of cycles.
- R3: The quarter-rate clock is high for two source cycles and low for two. Each of its rising edges falls on a rising edge of the half-rate clock. After reset its first rise comes with the first half-rate rise.
- R4: Bank k sits at bits [3k-1:3k-3] of `y` for k = 1..4. With `sel` as an unsigned number, bank k for k = 1..3 carries the quarter-rate clock when `sel` >= k, and carries the half-rate clock otherwise. Bank 4 always carries the half-rate clock.
- R5: While `oe_n` is high, all twelve bits of `y` are 0. The dividers keep running, so when the outputs are enabled again they show the phase that continuous counting gives.
- R6: A 1-to-0 change of `clr_in`, sampled at a rising edge, sets the quarter-rate clock to 0 at that edge. The half-rate clock keeps toggling. A rising change of `clr_in`, or holding it at either level, has no effect.
- R7: While `bypass` is high and `oe_n` is low, every output equals `clk_src` (high during the high phase, low during the low phase). With `oe_n` high the outputs stay low.
- R8: The three outputs of a bank always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset of both dividers |
| oe_n | input | 1 | High forces all outputs low |
| bypass | input | 1 | High routes `clk_src` straight to the outputs |
| clr_in | input | 1 | Falling edge clears the quarter-rate divider |
| sel | input | 2 | Number of banks (from bank 1 upward) that carry the quarter-rate clock |
| y | output | 12 (4*LANES) | Bank outputs, bank 1 in the low three bits |

## Verification
The divider state changes on the rising edge of `clk_src` at which it is sampled. A clear edge that falls before edge N therefore shows as a low quarter-rate output right after edge N. The enable, bypass and select act combinationally in the same cycle. The bench changes every input on the falling edge. It samples `y` 1 ns after each rising edge, where all of these effects have settled, and compares it with a behavioural model of the two divided clocks advanced on that same edge. For bypass it also samples 1 ns after the falling edge, so that the low phase of the source is seen on the outputs as well.

// File: rtl/clk_bank_divider.sv
module clk_bank_divider #(
  parameter int LANES = 3
) (
  input  logic                 clk_src,
  input  logic                 rst,
  input  logic                 oe_n,
  input  logic                 bypass,
  input  logic                 clr_in,
  input  logic [1:0]           sel,
  output logic [4*LANES-1:0]   y
);
  localparam int NBANK = 4;

  logic half_q;
  logic quarter_q;
  logic clr_q;
  logic clr_fall;

  assign clr_fall = clr_q & ~clr_in;

  always_ff @(posedge clk_src) clr_q <= clr_in;

  always_ff @(posedge clk_src) begin
    if (rst) begin
      half_q    <= 1'b0;
      quarter_q <= 1'b0;
    end else begin
      half_q <= ~half_q;
      if (clr_fall)
        quarter_q <= 1'b0;
      else if (!half_q)
        quarter_q <= ~quarter_q;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic src;
    if (b == NBANK - 1) begin : g_fixed
      assign src = half_q;
    end else begin : g_sel
      assign src = (sel >= 2'(b + 1)) ? quarter_q : half_q;
    end
    assign y[b*LANES +: LANES] = {LANES{~oe_n & (bypass ? clk_src : src)}};
  end
endmodule

// File: rtl/clk_bank_divider_chk.sv
module clk_bank_divider_chk #(
  parameter int LANES = 3
) (
  input logic               clk_src,
  input logic               rst,
  input logic               oe_n,
  input logic               bypass,
  input logic               clr_in,
  input logic [1:0]         sel,
  input logic               half_q,
  input logic               quarter_q,
  input logic [4*LANES-1:0] y
);
  // R2
  half_toggle_chk: assert property (@(posedge clk_src) disable iff (rst)
    !$past(rst) |-> half_q != $past(half_q));

  // R3
  quarter_align_chk: assert property (@(posedge clk_src) disable iff (rst)
    $rose(quarter_q) |-> $rose(half_q));

  // R6
  clear_low_chk: assert property (@(posedge clk_src) disable iff (rst)
    $fell(clr_in) |=> !quarter_q);

  // R5
  disable_low_chk: assert property (@(posedge clk_src) disable iff (rst)
    oe_n |-> y == '0);

  // R4
  fixed_bank_chk: assert property (@(posedge clk_src) disable iff (rst)
    (!oe_n && !bypass) |-> y[4*LANES-1 -: LANES] == {LANES{half_q}});

  // R4
  all_quarter_chk: assert property (@(posedge clk_src) disable iff (rst)
    (!oe_n && !bypass && sel == 2'b11) |-> y[3*LANES-1:0] == {(3*LANES){quarter_q}});
endmodule

bind clk_bank_divider clk_bank_divider_chk #(.LANES(LANES)) u_chk (
  .clk_src(clk_src), .rst(rst), .oe_n(oe_n), .bypass(bypass), .clr_in(clr_in),
  .sel(sel), .half_q(half_q), .quarter_q(quarter_q), .y(y)
);

// File: tb/sim_clk_bank_divider.sv
module sim_clk_bank_divider;
  localparam int LANES = 3;
  localparam int OUT_W = 4 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_n = 1'b0;
  logic bypass = 1'b0;
  logic clr_in = 1'b1;
  logic [1:0] sel = 2'b00;
  logic [OUT_W-1:0] y;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  clk_bank_divider #(.LANES(LANES)) u0 (
    .clk_src(clk), .rst(rst), .oe_n(oe_n), .bypass(bypass),
    .clr_in(clr_in), .sel(sel), .y(y)
  );

  task automatic chk(input bit ok, input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [OUT_W-1:0] model_y(input bit h, input bit q, input logic [1:0] s,
                                               input bit en_n, input bit byp, input bit ck);
    logic [OUT_W-1:0] v;
    for (int b = 0; b < 4; b++) begin
      bit src;
      src = (b == 3) ? h : ((int'(s) >= b + 1) ? q : h);
      for (int l = 0; l < LANES; l++)
        v[b*LANES+l] = en_n ? 1'b0 : (byp ? ck : src);
    end
    return v;
  endfunction

  bit mh = 1'b0, mq = 1'b0, mclr = 1'b1;

  always @(posedge clk) begin
    logic [OUT_W-1:0] e;
    string tag;
    if (rst) begin
      mh = 1'b0; mq = 1'b0;
    end else begin
      if (mclr && !clr_in) mq = 1'b0;
      else if (!mh) mq = ~mq;
      mh = ~mh;
    end
    mclr = clr_in;
    #1;
    e = model_y(mh, mq, sel, oe_n, bypass, 1'b1);
    tag = rst ? "R1" : (oe_n ? "R5" : (bypass ? "R7" : "R4"));
    chk(y === e, tag, y, e);
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", y, y);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt, tog, rises, mis, bad, wait_n;
    bit p9, p0;
    repeat (3) @(negedge clk);
    chk(y === '0, "R1", y, '0);
    rst = 1'b0;

    // R2: half-rate bank toggles every cycle, 50% duty
    p9 = y[9]; cnt = 0; tog = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (y[9]) cnt++;
      if (y[9] != p9) tog++;
      p9 = y[9];
    end
    chk(cnt == 20, "R2", OUT_W'(cnt), OUT_W'(20));
    chk(tog == 40, "R2", OUT_W'(tog), OUT_W'(40));

    // R4: every select code
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); sel = 2'(s);
      repeat (16) @(posedge clk);
    end

    // R3 and R8: quarter duty, alignment, bank uniformity
    @(negedge clk); sel = 2'b11;
    @(posedge clk); #1;
    p0 = y[0]; p9 = y[9]; cnt = 0; rises = 0; mis = 0; bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (y[0]) cnt++;
      if (!p0 && y[0]) begin
        rises++;
        if (!( !p9 && y[9])) mis++;
      end
      for (int b = 0; b < 4; b++)
        if (y[b*LANES +: LANES] != '0 && y[b*LANES +: LANES] != '1) bad++;
      p0 = y[0]; p9 = y[9];
    end
    chk(cnt == 20, "R3", OUT_W'(cnt), OUT_W'(20));
    chk(rises == 10, "R3", OUT_W'(rises), OUT_W'(10));
    chk(mis == 0, "R3", OUT_W'(mis), '0);
    chk(bad == 0, "R8", OUT_W'(bad), '0);

    // R6: clear while the quarter clock is high
    do begin @(posedge clk); #1; end while (!y[0]);
    @(negedge clk); p9 = y[9]; clr_in = 1'b0;
    @(posedge clk); #1;
    chk(y[0] == 1'b0, "R6", y, {y[OUT_W-1:1], 1'b0});
    chk(y[9] == !p9, "R6", y, {y[OUT_W-1:10], !p9, y[8:0]});
    p0 = y[0]; p9 = y[9]; wait_n = 0;
    do begin
      @(posedge clk); #1; wait_n++;
      if (!p0 && y[0]) break;
      p0 = y[0]; p9 = y[9];
    end while (wait_n < 8);
    chk(wait_n <= 2 && y[9] && !p9, "R6", OUT_W'(wait_n), OUT_W'(2));
    repeat (6) @(negedge clk);
    clr_in = 1'b1;
    repeat (8) @(posedge clk);

    // R5: disabled outputs stay low, dividers keep running
    @(negedge clk); oe_n = 1'b1; bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1; if (y != '0) bad++;
      @(negedge clk); #1; if (y != '0) bad++;
    end
    chk(bad == 0, "R5", OUT_W'(bad), '0);
    oe_n = 1'b0;
    repeat (8) @(posedge clk);

    // R7: bypass follows the source clock
    @(negedge clk); bypass = 1'b1;
    @(posedge clk); #1; chk(y === '1, "R7", y, '1);
    @(negedge clk); #1; chk(y === '0, "R7", y, '0);
    oe_n = 1'b1;
    @(posedge clk); #1; chk(y === '0, "R7", y, '0);
    @(negedge clk); oe_n = 1'b0; bypass = 1'b0; sel = 2'b01;
    repeat (8) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule